// File: doc/BRIEF.md
# Pin Interrupt Detector and Edge Latch

This block turns the levels of a 32-pin I/O bank into a single interrupt request. The pins arrive already synchronized to the block clock. Each pin has its own trigger choice: it can fire on a rising edge, a falling edge, a high level or a low level. Each pin also has an enable bit and a mask bit. A read-only status word shows which pins are requesting service, and the interrupt line is raised while any status bit is set.

Software configures the block through a simple 32-bit write/read register port. Every configuration register is split into two 16-bit halves, one for pins 0..15 and one for pins 16..31. In each half, data bit k is written only when write-enable bit k+16 of the same word is set. This lets one pin be changed without a read-modify-write sequence. The end-of-interrupt register uses the same rule to clear latched edges.

Edge events stay latched until software clears them. Level sources are not latched and follow the pin directly.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, all 32 mask bits read back as 1 (`0x0000FFFF` from each mask half). All enable, type and polarity bits read back as 0. Status reads 0 and `irq_o` is low.
- R2: A write to a configuration half changes bit k of that half only when write data bit k+16 is 1. The new value is data bit k. Half offsets (low/high) are: enable 0x10/0x14, mask 0x18/0x1C, type 0x20/0x24, polarity 0x28/0x2C. The low half holds pins 0..15 and the high half holds pins 16..31. A half reads back as `{16'h0, bits}`.
- R3: A type bit of 1 selects edge triggering and a type bit of 0 selects level triggering. A polarity bit of 1 selects rising or high. A polarity bit of 0 selects falling or low. An edge of the opposite direction is not latched.
- R4: The pin value is compared with the value it had at the previous clock edge. A matching edge that is present at a clock edge sets the pin's pending latch, and the latch is visible right after that edge.
- R5: A pending edge stays set after the pin returns to its old level. It is cleared only by a write to end-of-interrupt low/high (0x60/0x64) with both bit k and bit k+16 set. An end-of-interrupt write with bit k+16 clear has no effect.
- R6: A level-triggered pin is not latched. Its status bit follows the pin in the same cycle and drops as soon as the pin becomes inactive.
- R7: The status word at 0x50 has bit n for pin n. It equals the raw request AND enable AND NOT mask.
- R8: `irq_o` is the OR of all 32 status bits.
- R9: If an end-of-interrupt clear and a new matching edge on the same pin occur at the same clock edge, the pin stays pending.
- R10: Configuration registers hold their value in every cycle without a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 32 | Synchronized pin levels |
| bus_wr | input | 1 | Register write strobe for this cycle |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data: enables in [31:16], values in [15:0] |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume the following about the inputs:
- `pin_i` is already synchronous to `clk` and is held at zero during reset. Otherwise the first sample after reset could look like an edge.
- Writes arrive as single-cycle strobes with a stable address and data.

The bench drives pins and bus signals only on the falling clock edge. It keeps every pin low while reset is active. Its random writes use only the defined register offsets. Random pin toggles let edges, levels, clears and writes coincide freely, including an end-of-interrupt clear in the same cycle as a new edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int HALF_W = 16;

    localparam logic [7:0] OFF_EN   = 8'h10;
    localparam logic [7:0] OFF_MASK = 8'h18;
    localparam logic [7:0] OFF_TYPE = 8'h20;
    localparam logic [7:0] OFF_POL  = 8'h28;
    localparam logic [7:0] OFF_STAT = 8'h50;
    localparam logic [7:0] OFF_EOI  = 8'h60;

    // byte offset of half h of a register starting at base
    function automatic logic [7:0] half_addr(input logic [7:0] base, input int h);
        return base + 8'(4 * h);
    endfunction
endpackage

// File: rtl/gpio_half_reg.sv
// Pin-wide register written through 16-bit halves with per-bit write enables.
module gpio_half_reg
    import gpio_irq_pkg::*;
#(
    parameter int          NPINS  = 32,
    parameter int          ADDR_W = 8,
    parameter logic [7:0]  BASE   = 8'h10,
    parameter logic [NPINS-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [NPINS-1:0]  q
);
    localparam int NHALF = NPINS / HALF_W;

    logic [NPINS-1:0] q_next;

    always_comb begin
        q_next = q;
        for (int h = 0; h < NHALF; h++) begin
            if (wr_en && addr == ADDR_W'(half_addr(BASE, h))) begin
                for (int k = 0; k < HALF_W; k++) begin
                    if (wdata[k + HALF_W]) begin
                        q_next[h * HALF_W + k] = wdata[k];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else begin
            q <= q_next;
        end
    end
endmodule

// File: rtl/gpio_edge_latch.sv
// Per-pin edge detector against the previous sample, with a pending latch.
module gpio_edge_latch #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    input  logic [NPINS-1:0] type_q,
    input  logic [NPINS-1:0] pol_q,
    input  logic [NPINS-1:0] clr,
    output logic [NPINS-1:0] pend
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic prev;
        logic hit;

        // edge of the selected direction, only for edge-typed pins
        assign hit = type_q[i] & (pol_q[i] ? (pin_i[i] & ~prev)
                                           : (~pin_i[i] & prev));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev    <= 1'b0;
                pend[i] <= 1'b0;
            end else begin
                prev    <= pin_i[i];
                // a new edge overrides a clear in the same cycle
                pend[i] <= (pend[i] & ~clr[i]) | hit;
            end
        end
    end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_i,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    localparam int NHALF = NPINS / HALF_W;

    logic [NPINS-1:0] en_q;
    logic [NPINS-1:0] mask_q;
    logic [NPINS-1:0] type_q;
    logic [NPINS-1:0] pol_q;
    logic [NPINS-1:0] edge_pend;
    logic [NPINS-1:0] eoi_clr;
    logic [NPINS-1:0] level_act;
    logic [NPINS-1:0] raw_req;
    logic [NPINS-1:0] status;

    gpio_half_reg #(.NPINS(NPINS), .ADDR_W(ADDR_W), .BASE(OFF_EN), .RST_VAL('0)) u_en (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .q(en_q));

    gpio_half_reg #(.NPINS(NPINS), .ADDR_W(ADDR_W), .BASE(OFF_MASK), .RST_VAL('1)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .q(mask_q));

    gpio_half_reg #(.NPINS(NPINS), .ADDR_W(ADDR_W), .BASE(OFF_TYPE), .RST_VAL('0)) u_type (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .q(type_q));

    gpio_half_reg #(.NPINS(NPINS), .ADDR_W(ADDR_W), .BASE(OFF_POL), .RST_VAL('0)) u_pol (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .q(pol_q));

    // end-of-interrupt: clear bit k where both value and enable are set
    always_comb begin
        eoi_clr = '0;
        for (int h = 0; h < NHALF; h++) begin
            if (bus_wr && bus_addr == ADDR_W'(half_addr(OFF_EOI, h))) begin
                eoi_clr[h * HALF_W +: HALF_W] =
                    bus_wdata[HALF_W +: HALF_W] & bus_wdata[0 +: HALF_W];
            end
        end
    end

    gpio_edge_latch #(.NPINS(NPINS)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .type_q(type_q),
        .pol_q(pol_q), .clr(eoi_clr), .pend(edge_pend));

    assign level_act = ~(pin_i ^ pol_q);
    assign raw_req   = (type_q & edge_pend) | (~type_q & level_act);
    assign status    = raw_req & en_q & ~mask_q;
    assign irq_o     = |status;

    // read-back mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_STAT)) begin
            bus_rdata = 32'(status);
        end
        for (int h = 0; h < NHALF; h++) begin
            if (bus_addr == ADDR_W'(half_addr(OFF_EN, h))) begin
                bus_rdata = {16'h0, en_q[h * HALF_W +: HALF_W]};
            end
            if (bus_addr == ADDR_W'(half_addr(OFF_MASK, h))) begin
                bus_rdata = {16'h0, mask_q[h * HALF_W +: HALF_W]};
            end
            if (bus_addr == ADDR_W'(half_addr(OFF_TYPE, h))) begin
                bus_rdata = {16'h0, type_q[h * HALF_W +: HALF_W]};
            end
            if (bus_addr == ADDR_W'(half_addr(OFF_POL, h))) begin
                bus_rdata = {16'h0, pol_q[h * HALF_W +: HALF_W]};
            end
        end
    end
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NPINS-1:0]  pin_i,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              irq_o,
    input logic [NPINS-1:0]  en_q,
    input logic [NPINS-1:0]  mask_q,
    input logic [NPINS-1:0]  type_q,
    input logic [NPINS-1:0]  pol_q,
    input logic [NPINS-1:0]  pend_q
);
    localparam int NHALF = NPINS / HALF_W;

    logic [NPINS-1:0] pin_d;
    logic [NPINS-1:0] det;
    logic [NPINS-1:0] clr_seen;
    logic [NPINS-1:0] keep;
    logic [NPINS-1:0] lvl_live;

    always_ff @(posedge clk) begin
        if (!rst_n) pin_d <= '0;
        else        pin_d <= pin_i;
    end

    always_comb begin
        clr_seen = '0;
        for (int h = 0; h < NHALF; h++) begin
            for (int k = 0; k < HALF_W; k++) begin
                if (bus_wr && bus_addr == ADDR_W'(half_addr(OFF_EOI, h)) &&
                    bus_wdata[k] && bus_wdata[k + HALF_W]) begin
                    clr_seen[h * HALF_W + k] = 1'b1;
                end
            end
        end
    end

    assign det      = type_q & ((pol_q & pin_i & ~pin_d) | (~pol_q & ~pin_i & pin_d));
    assign keep     = pend_q & ~clr_seen;
    assign lvl_live = ~type_q & en_q & ~mask_q & ~(pin_i ^ pol_q);

    // R4, R9: a matching edge is pending after the clock, clear or not
    p_edge_sets_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(det)) == $past(det)));

    // R5: pending bits survive unless cleared through end-of-interrupt
    p_pend_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(keep)) == $past(keep)));

    // R6: an active, enabled, unmasked level source drives the line now
    p_level_drives_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_live != '0) |-> irq_o);

    // R7: no request without some enabled and unmasked pin
    p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((en_q & ~mask_q) != '0));

    // R10: configuration is stable without a write
    p_cfg_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(en_q) && $stable(mask_q) && $stable(type_q) && $stable(pol_q)));
endmodule

bind gpio_irq_unit gpio_irq_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_o(irq_o),
    .en_q(en_q), .mask_q(mask_q), .type_q(type_q), .pol_q(pol_q),
    .pend_q(edge_pend));

// File: tb/sim_gpio_irq_unit.sv
module sim_gpio_irq_unit;
    localparam logic [7:0] A_EN   = 8'h10;
    localparam logic [7:0] A_MASK = 8'h18;
    localparam logic [7:0] A_TYPE = 8'h20;
    localparam logic [7:0] A_POL  = 8'h28;
    localparam logic [7:0] A_STAT = 8'h50;
    localparam logic [7:0] A_EOI  = 8'h60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_i = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // reference model
    logic [31:0] m_en, m_mask, m_typ, m_pol, m_pend, m_prev;

    always #4 clk = ~clk;

    gpio_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o));

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [7:0] base,
                                          input logic [7:0] a, input logic [31:0] d);
        logic [31:0] r = old;
        for (int h = 0; h < 2; h++) begin
            if (a == base + 8'(4 * h)) begin
                for (int k = 0; k < 16; k++) begin
                    if (d[k + 16]) r[16 * h + k] = d[k];
                end
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_status(input logic [31:0] pins);
        logic [31:0] raw = (m_typ & m_pend) | (~m_typ & ~(pins ^ m_pol));
        return raw & m_en & ~m_mask;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_clock(input logic [31:0] pins, input logic wr,
                               input logic [7:0] a, input logic [31:0] d);
        logic [31:0] det, clr;
        det = m_typ & ((m_pol & pins & ~m_prev) | (~m_pol & ~pins & m_prev));
        clr = '0;
        if (wr && a == A_EOI)       clr[15:0]  = d[31:16] & d[15:0];
        if (wr && a == A_EOI + 8'd4) clr[31:16] = d[31:16] & d[15:0];
        m_pend = (m_pend & ~clr) | det;
        m_prev = pins;
        if (wr) begin
            m_en   = merge(m_en, A_EN, a, d);
            m_mask = merge(m_mask, A_MASK, a, d);
            m_typ  = merge(m_typ, A_TYPE, a, d);
            m_pol  = merge(m_pol, A_POL, a, d);
        end
    endtask

    // drive at falling edge, model updates at the rising edge
    task automatic step(input logic [31:0] pins, input logic wr,
                        input logic [7:0] a, input logic [31:0] d);
        pin_i = pins; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_clock(pins, wr, a, d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic chk_status(input string req);
        logic [31:0] e;
        bus_addr = A_STAT;
        #1;
        e = exp_status(pin_i);
        chk(req, bus_rdata, e);
        chk(req, {31'h0, irq_o}, {31'h0, |e});
    endtask

    task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] e);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, e);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        m_en = '0; m_mask = '1; m_typ = '0; m_pol = '0; m_pend = '0; m_prev = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_reg("R1 mask lo", A_MASK, 32'h0000_FFFF);
        chk_reg("R1 mask hi", A_MASK + 8'd4, 32'h0000_FFFF);
        chk_reg("R1 en lo", A_EN, 32'h0);
        chk_reg("R1 type hi", A_TYPE + 8'd4, 32'h0);
        chk_reg("R1 status", A_STAT, 32'h0);
        chk("R1 irq", {31'h0, irq_o}, 32'h0);

        // R2 partial half writes
        step(32'h0, 1'b1, A_EN, 32'h0003_00FF);
        chk_reg("R2 en lo write-enable gating", A_EN, 32'h0000_0003);
        step(32'h0, 1'b1, A_EN + 8'd4, 32'h8000_8000);
        chk_reg("R2 en hi pin31", A_EN + 8'd4, 32'h0000_8000);
        chk_reg("R2 en lo untouched", A_EN, 32'h0000_0003);

        // pin0 rising edge, unmasked
        step(32'h0, 1'b1, A_TYPE, 32'h0001_0001);
        step(32'h0, 1'b1, A_POL, 32'h0001_0001);
        step(32'h0, 1'b1, A_MASK, 32'h0001_0000);
        chk_reg("R2 mask lo pin0 only", A_MASK, 32'h0000_FFFE);
        chk_reg("R1 status quiet", A_STAT, 32'h0);
        // R4 edge latched
        step(32'h1, 1'b0, 8'h0, 32'h0);
        chk_reg("R4 rising edge pending", A_STAT, 32'h1);
        chk("R8 irq on edge", {31'h0, irq_o}, 32'h1);
        // R5 hold and clear
        step(32'h0, 1'b0, 8'h0, 32'h0);
        chk_reg("R5 held after pin falls", A_STAT, 32'h1);
        step(32'h0, 1'b1, A_EOI, 32'h0000_0001);
        chk_reg("R5 eoi without enable ignored", A_STAT, 32'h1);
        step(32'h0, 1'b1, A_EOI, 32'h0001_0001);
        chk_reg("R5 eoi clears", A_STAT, 32'h0);
        chk("R8 irq low", {31'h0, irq_o}, 32'h0);
        // R9 clear collides with new edge
        step(32'h1, 1'b1, A_EOI, 32'h0001_0001);
        chk_reg("R9 new edge wins over clear", A_STAT, 32'h1);

        // R3 pin1 falling edge
        step(32'h1, 1'b1, A_TYPE, 32'h0002_0002);
        step(32'h1, 1'b1, A_POL, 32'h0002_0000);
        step(32'h1, 1'b1, A_MASK, 32'h0002_0000);
        step(32'h3, 1'b1, A_EOI, 32'h0001_0001);
        chk_reg("R3 rise ignored on falling pin", A_STAT, 32'h0);
        step(32'h1, 1'b0, 8'h0, 32'h0);
        chk_reg("R3 falling edge pending", A_STAT, 32'h2);
        step(32'h1, 1'b1, A_EOI, 32'h0002_0002);

        // R6 pin31 high level
        step(32'h1, 1'b1, A_POL + 8'd4, 32'h8000_8000);
        step(32'h1, 1'b1, A_MASK + 8'd4, 32'h8000_0000);
        chk_reg("R6 level inactive", A_STAT, 32'h0);
        pin_i = 32'h8000_0001;
        chk_reg("R6 level follows pin same cycle", A_STAT, 32'h8000_0000);
        step(32'h8000_0001, 1'b0, 8'h0, 32'h0);
        step(32'h0000_0001, 1'b0, 8'h0, 32'h0);
        chk_reg("R6 level not latched", A_STAT, 32'h0);
        chk_status("R7 model after directed");

        // random phase
        for (int i = 0; i < 600; i++) begin
            logic [31:0] pins, d;
            logic [7:0] a;
            logic wr;
            logic [7:0] offs [6] = '{A_EN, A_MASK, A_TYPE, A_POL, A_EOI, A_EOI};
            pins = pin_i ^ ($urandom % 4 == 0 ? $urandom : 32'h0);
            wr   = ($urandom % 2) == 1;
            a    = offs[$urandom % 6] + 8'(4 * ($urandom % 2));
            d    = $urandom;
            step(pins, wr, a, d);
            chk_status("R7 R8 random status");
            if (i % 16 == 0) begin
                chk_reg("R10 en lo", A_EN, {16'h0, m_en[15:0]});
                chk_reg("R10 mask hi", A_MASK + 8'd4, {16'h0, m_mask[31:16]});
                chk_reg("R2 type lo", A_TYPE, {16'h0, m_typ[15:0]});
                chk_reg("R2 pol hi", A_POL + 8'd4, {16'h0, m_pol[31:16]});
            end
        end

        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule